// File: doc/BRIEF.md
# Buffer Control Message Decoder

This block sits on the receiving end of a buffer unit's external control port. Each clock it may receive one 12-bit control message, qualified by a valid strobe. The upper four bits give the message kind and the lower eight bits carry a value. Depending on the kind, the value becomes one of four latched registers: the write buffer number used on a first-level accept, the read (scan) buffer number used on a second-level accept, the bunch crossing number, or the event label. Two further kinds act as commands. One wipes the error flags and touches nothing else. The other issues a full restart.

The block also holds the 8-bit status word that is reported back to the controller. The two busy bits reflect their sources live. The six error bits latch local fault events and hold them until the controller clears them. An unknown message kind raises its own error bit. A crossing number that disagrees with the locally expected one raises the identifier error. Every latched output updates on the clock edge that samples the message.

Top module: `bufctl_msg_decoder`

## Requirements
- R1: A valid message of kind 1 (bits 11..8 = 1) loads bits 7..0 into `wr_buf_o` on the sampling edge. The other three latched values are left unchanged.
- R2: A valid message of kind 4 loads `rd_buf_o`, and a valid message of kind 5 loads `evt_label_o`, both on the sampling edge.
- R3: A valid message of kind 3 loads `bx_num_o`. If its value differs from `expected_bx_i`, status bit 4 (identifier error) becomes set.
- R4: A message presented while `msg_valid_i` is low changes no latched value and no status bit, and it produces no restart pulse.
- R5: A valid message of kind 0, 2, 6 through 12, or 15 sets status bit 6 (controller error) and changes no latched value.
- R6: A high level on the local fault inputs sets its status bit: sync sets bit 2, frame sets bit 3, identifier sets bit 4, format sets bit 5, overflow sets bit 7. The bit stays set after the input drops.
- R7: A valid message of kind 13 clears status bits 2 through 7. It leaves all latched values unchanged and produces no restart pulse.
- R8: A valid message of kind 14 drives `restart_o` high for exactly the following cycle. It zeroes all four latched values and clears status bits 2 through 7.
- R9: A fault input that is high in the same cycle as a clearing message (kind 13 or 14) still leaves its status bit set afterwards.
- R10: Status bit 0 equals `busy_in_i` and status bit 1 equals `busy_out_i` combinationally, with no clock delay.
- R11: While `rst_n` is low, every latched value, `restart_o` and status bits 2 through 7 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_word_i | input | 12 | Control message: kind in bits 11..8, value in bits 7..0 |
| msg_valid_i | input | 1 | Message qualifier |
| expected_bx_i | input | 8 | Locally expected crossing number |
| flt_sync_i | input | 1 | Data link sync fault event |
| flt_frame_i | input | 1 | Invalid data word event |
| flt_ident_i | input | 1 | Event identifier fault event |
| flt_format_i | input | 1 | Data format fault event |
| flt_ovfl_i | input | 1 | Buffer overflow event |
| busy_in_i | input | 1 | Input buffer busy source |
| busy_out_i | input | 1 | Output buffer busy source |
| wr_buf_o | output | 8 | Latched write buffer number |
| rd_buf_o | output | 8 | Latched read buffer number |
| bx_num_o | output | 8 | Latched crossing number |
| evt_label_o | output | 8 | Latched event label |
| restart_o | output | 1 | One-cycle restart pulse |
| status_o | output | 8 | Busy and sticky error status |

## Verification
Loads of each kind are sent with distinct values. This shows that every kind steers into its own register and leaves the others alone. The same load word is then sent with the strobe low, which must leave everything unchanged. Several unused kinds are sent, including both ends of the code range, to separate the controller error from a silent drop. Crossing numbers that match and that mismatch the expected value are both sent. Fault events are then combined with both clearing kinds in the same cycle, which shows whether a new event survives the clear. A restart that follows loaded registers shows that the zeroing and the single-cycle pulse both happen.

// File: rtl/bufctl_pkg.sv
package bufctl_pkg;

    localparam int MSG_W  = 12;
    localparam int KIND_W = 4;
    localparam int VAL_W  = 8;
    localparam int NFLD   = 4;
    localparam int NERR   = 6;

    // latched field slots
    localparam int FLD_WR  = 0;
    localparam int FLD_RD  = 1;
    localparam int FLD_BX  = 2;
    localparam int FLD_EVT = 3;

    // error slot order inside the sticky vector (maps to status bits 2..7)
    localparam int ERR_SYNC   = 0;
    localparam int ERR_FRAME  = 1;
    localparam int ERR_IDENT  = 2;
    localparam int ERR_FORMAT = 3;
    localparam int ERR_CTRL   = 4;
    localparam int ERR_OVFL   = 5;

    typedef enum logic [KIND_W-1:0] {
        K_WRBUF   = 4'd1,
        K_BX      = 4'd3,
        K_RDBUF   = 4'd4,
        K_EVT     = 4'd5,
        K_CLRERR  = 4'd13,
        K_RESTART = 4'd14
    } msg_kind_e;

    typedef struct packed {
        logic [NFLD-1:0]  ld;
        logic             clr_err;
        logic             restart;
        logic             bad_kind;
        logic [VAL_W-1:0] value;
    } msg_act_t;

endpackage

// File: rtl/bufctl_decode.sv
module bufctl_decode
    import bufctl_pkg::*;
(
    input  logic             valid_i,
    input  logic [MSG_W-1:0] word_i,
    output msg_act_t         act_o
);

    logic [KIND_W-1:0] kind;

    always_comb begin
        kind         = word_i[MSG_W-1 -: KIND_W];
        act_o        = '0;
        act_o.value  = word_i[VAL_W-1:0];
        if (valid_i) begin
            case (kind)
                K_WRBUF:   act_o.ld[FLD_WR]  = 1'b1;
                K_RDBUF:   act_o.ld[FLD_RD]  = 1'b1;
                K_BX:      act_o.ld[FLD_BX]  = 1'b1;
                K_EVT:     act_o.ld[FLD_EVT] = 1'b1;
                K_CLRERR:  act_o.clr_err     = 1'b1;
                K_RESTART: act_o.restart     = 1'b1;
                default:   act_o.bad_kind    = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/bufctl_field_regs.sv
module bufctl_field_regs
    import bufctl_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  msg_act_t                       act_i,
    output logic [NFLD-1:0][VAL_W-1:0]     fld_o,
    output logic                           pulse_o
);

    typedef struct packed {
        logic [NFLD-1:0][VAL_W-1:0] fld;
        logic                       pulse;
    } fstate_t;

    fstate_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = act_i.restart;
        for (int i = 0; i < NFLD; i++) begin
            if (act_i.ld[i]) s_d.fld[i] = act_i.value;
        end
        if (act_i.restart) s_d.fld = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fld_o   = s_q.fld;
    assign pulse_o = s_q.pulse;

    for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld_chk
        // R1
        field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act_i.ld[gi] |=> (fld_o[gi] == $past(act_i.value)));
        // R4
        field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!act_i.ld[gi] && !act_i.restart) |=> $stable(fld_o[gi]));
    end

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (fld_o == '0));
    // R8
    restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.restart |=> pulse_o);
    // R4
    restart_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i.restart |=> !pulse_o);

endmodule

// File: rtl/bufctl_status_regs.sv
module bufctl_status_regs
    import bufctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  msg_act_t         act_i,
    input  logic [VAL_W-1:0] expected_bx_i,
    input  logic             flt_sync_i,
    input  logic             flt_frame_i,
    input  logic             flt_ident_i,
    input  logic             flt_format_i,
    input  logic             flt_ovfl_i,
    input  logic             busy_in_i,
    input  logic             busy_out_i,
    output logic [7:0]       status_o
);

    typedef struct packed {
        logic [NERR-1:0] err;
    } sstate_t;

    sstate_t         s_d, s_q;
    logic [NERR-1:0] ev;
    logic            bx_mismatch;
    logic            clr;

    always_comb begin
        bx_mismatch     = act_i.ld[FLD_BX] && (act_i.value != expected_bx_i);
        clr             = act_i.clr_err || act_i.restart;
        ev              = '0;
        ev[ERR_SYNC]    = flt_sync_i;
        ev[ERR_FRAME]   = flt_frame_i;
        ev[ERR_IDENT]   = flt_ident_i || bx_mismatch;
        ev[ERR_FORMAT]  = flt_format_i;
        ev[ERR_CTRL]    = act_i.bad_kind;
        ev[ERR_OVFL]    = flt_ovfl_i;
        s_d             = s_q;
        if (clr) s_d.err = '0;
        s_d.err         = s_d.err | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = {s_q.err, busy_out_i, busy_in_i};

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status_o[7:2] & $past(status_o[7:2])) == $past(status_o[7:2])));
    // R5
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.bad_kind |=> status_o[6]);
    // R3
    bx_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bx_mismatch |=> status_o[4]);
    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev == '0) |=> (status_o[7:2] == '0));
    // R9
    ev_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && flt_ovfl_i) |=> status_o[7]);

endmodule

// File: rtl/bufctl_msg_decoder.sv
module bufctl_msg_decoder
    import bufctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] msg_word_i,
    input  logic        msg_valid_i,
    input  logic [7:0]  expected_bx_i,
    input  logic        flt_sync_i,
    input  logic        flt_frame_i,
    input  logic        flt_ident_i,
    input  logic        flt_format_i,
    input  logic        flt_ovfl_i,
    input  logic        busy_in_i,
    input  logic        busy_out_i,
    output logic [7:0]  wr_buf_o,
    output logic [7:0]  rd_buf_o,
    output logic [7:0]  bx_num_o,
    output logic [7:0]  evt_label_o,
    output logic        restart_o,
    output logic [7:0]  status_o
);

    msg_act_t                   act;
    logic [NFLD-1:0][VAL_W-1:0] fld;

    bufctl_decode u_decode (
        .valid_i (msg_valid_i),
        .word_i  (msg_word_i),
        .act_o   (act)
    );

    bufctl_field_regs u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .fld_o   (fld),
        .pulse_o (restart_o)
    );

    bufctl_status_regs u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_i         (act),
        .expected_bx_i (expected_bx_i),
        .flt_sync_i    (flt_sync_i),
        .flt_frame_i   (flt_frame_i),
        .flt_ident_i   (flt_ident_i),
        .flt_format_i  (flt_format_i),
        .flt_ovfl_i    (flt_ovfl_i),
        .busy_in_i     (busy_in_i),
        .busy_out_i    (busy_out_i),
        .status_o      (status_o)
    );

    assign wr_buf_o    = fld[FLD_WR];
    assign rd_buf_o    = fld[FLD_RD];
    assign bx_num_o    = fld[FLD_BX];
    assign evt_label_o = fld[FLD_EVT];

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (restart_o == 1'b0 && status_o[7:2] == '0 && wr_buf_o == '0));

endmodule

// File: tb/bufctl_msg_decoder_tb.sv
module bufctl_msg_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] msg_word = '0;
    logic        msg_valid = 1'b0;
    logic [7:0]  expected_bx = 8'h00;
    logic        f_sync = 0, f_frame = 0, f_ident = 0, f_format = 0, f_ovfl = 0;
    logic        busy_in = 0, busy_out = 0;
    logic [7:0]  wr_buf, rd_buf, bx_num, evt_label, status;
    logic        restart;

    always #4 clk = ~clk;

    bufctl_msg_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .msg_word_i(msg_word), .msg_valid_i(msg_valid),
        .expected_bx_i(expected_bx), .flt_sync_i(f_sync), .flt_frame_i(f_frame),
        .flt_ident_i(f_ident), .flt_format_i(f_format), .flt_ovfl_i(f_ovfl),
        .busy_in_i(busy_in), .busy_out_i(busy_out), .wr_buf_o(wr_buf),
        .rd_buf_o(rd_buf), .bx_num_o(bx_num), .evt_label_o(evt_label),
        .restart_o(restart), .status_o(status)
    );

    typedef struct {
        logic [7:0] wr, rd, bx, evt;
        logic [5:0] err;
        logic       rp;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0;

    // model state; err bit order: sync, frame, ident, format, ctrl, ovfl -> status 2..7
    logic [7:0] m_wr = 0, m_rd = 0, m_bx = 0, m_evt = 0;
    logic [5:0] m_err = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected outcome
    task automatic step(input logic v, input logic [3:0] k, input logic [7:0] val,
                        input logic [4:0] ev, input string req);
        exp_t e;
        logic rp;
        @(negedge clk);
        msg_valid = v;
        msg_word  = {k, val};
        {f_ovfl, f_format, f_ident, f_frame, f_sync} = ev;
        rp = 1'b0;
        if (v && (k == 4'd13 || k == 4'd14)) m_err = '0;
        m_err[0] |= ev[0];
        m_err[1] |= ev[1];
        m_err[2] |= ev[2];
        m_err[3] |= ev[3];
        m_err[5] |= ev[4];
        if (v) begin
            case (k)
                4'd1:  m_wr = val;
                4'd3:  begin m_bx = val; if (val != expected_bx) m_err[2] = 1'b1; end
                4'd4:  m_rd = val;
                4'd5:  m_evt = val;
                4'd13: ;
                4'd14: begin m_wr = 0; m_rd = 0; m_bx = 0; m_evt = 0; rp = 1'b1; end
                default: m_err[4] = 1'b1;
            endcase
        end
        e.wr = m_wr; e.rd = m_rd; e.bx = m_bx; e.evt = m_evt;
        e.err = m_err; e.rp = rp; e.req = req;
        q.push_back(e);
    endtask

    // monitor: compare just after the edge that registers each pushed cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " fields"}, {wr_buf, rd_buf, bx_num, evt_label},
                      {e.wr, e.rd, e.bx, e.evt});
                check({e.req, " errors"}, {26'd0, status[7:2]}, {26'd0, e.err});
                check({e.req, " restart"}, {31'd0, restart}, {31'd0, e.rp});
            end
        end
    end

    bit done = 0;
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        expected_bx = 8'h5A;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {wr_buf, rd_buf, bx_num, evt_label}, 32'd0);
        check("R11 reset status", {23'd0, restart, status}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 4'd1, 8'h11, 5'b0, "R1 wr load");
        step(1, 4'd4, 8'h22, 5'b0, "R2 rd load");
        step(1, 4'd5, 8'h33, 5'b0, "R2 evt load");
        step(1, 4'd3, 8'h5A, 5'b0, "R3 bx match");
        step(1, 4'd1, 8'hFE, 5'b0, "R1 wr reload");
        step(0, 4'd1, 8'h77, 5'b0, "R4 valid low");
        step(0, 4'd14, 8'h00, 5'b0, "R4 valid low restart");
        step(1, 4'd3, 8'h44, 5'b0, "R3 bx mismatch");
        step(1, 4'd13, 8'h00, 5'b0, "R7 clear");
        step(1, 4'd0, 8'h99, 5'b0, "R5 kind 0");
        step(1, 4'd13, 8'h00, 5'b0, "R7 clear");
        step(1, 4'd2, 8'h99, 5'b0, "R5 kind 2");
        step(1, 4'd7, 8'h99, 5'b0, "R5 kind 7");
        step(1, 4'd15, 8'h99, 5'b0, "R5 kind 15");
        step(1, 4'd13, 8'h00, 5'b0, "R7 clear");
        step(0, 4'd0, 8'h00, 5'b00001, "R6 sync");
        step(0, 4'd0, 8'h00, 5'b00010, "R6 frame");
        step(0, 4'd0, 8'h00, 5'b00100, "R6 ident");
        step(0, 4'd0, 8'h00, 5'b01000, "R6 format");
        step(0, 4'd0, 8'h00, 5'b10000, "R6 ovfl");
        step(0, 4'd0, 8'h00, 5'b00000, "R6 sticky");
        step(1, 4'd13, 8'h00, 5'b10000, "R9 clear with ovfl");
        step(1, 4'd13, 8'h00, 5'b00000, "R7 clear");
        step(1, 4'd14, 8'h00, 5'b00010, "R9 restart with frame");
        step(1, 4'd1, 8'h0C, 5'b0, "R1 after restart");
        step(1, 4'd5, 8'hC3, 5'b0, "R2 evt");
        step(1, 4'd7, 8'h01, 5'b0, "R5 before restart");
        step(1, 4'd14, 8'h00, 5'b0, "R8 restart");
        step(0, 4'd0, 8'h00, 5'b0, "R8 pulse ends");
        step(0, 4'd0, 8'h00, 5'b0, "R8 idle");

        // R10: busy bits follow sources combinationally
        @(negedge clk);
        busy_in = 1'b1; busy_out = 1'b0;
        #1 check("R10 busy in", {30'd0, status[1:0]}, 32'd1);
        busy_in = 1'b0; busy_out = 1'b1;
        #1 check("R10 busy out", {30'd0, status[1:0]}, 32'd2);
        busy_in = 1'b1;
        #1 check("R10 busy both", {30'd0, status[1:0]}, 32'd3);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule